// File: doc/BRIEF.md
# Non-Overlapping Pattern Output Controller

This block holds a 16-bit output pattern and changes it at instants set by an external timer. Software loads the next pattern into a staging register through a small address/data register port. Two single-cycle compare strobes from the timer then move staged bits into the live pattern register. A per-bit enable mask limits which bits a strobe may move.

The block has two modes. In normal mode only the first strobe (A) moves bits, and the second strobe (B) does nothing. In non-overlapping mode, strobe A copies every enabled staged bit. Strobe B copies only the enabled staged bits that are 0. So when the timer fires B before A, outputs that are about to fall drop early and outputs that are about to rise wait for A. This leaves a dead gap between pattern phases.

Each pin is driven by the pattern only when its direction bit selects output. An alternate-function select per bit hands the pin to another source with its own value. The pattern register keeps updating while a pin is handed over.

Top module: `pattern_out_ctrl`

## Requirements
- R1: After reset the staging, enable, direction, mode and pattern registers are all 0, and so are `pin_out` and `pin_oe`.
- R2: A write with `wr_en` high at address 0 (staging), 1 (enable), 2 (direction) or 3 (mode, bit 0 only) takes effect at the clock edge. `rdata` returns the register at `addr` combinationally. Mode bits 15:1 read as 0.
- R3: Address 4 reads the pattern register. A write to address 4 leaves it unchanged.
- R4: A one-cycle `cmp_a` pulse sets each pattern bit whose enable is 1 to its staged value at the next clock edge. Bits whose enable is 0 keep their value.
- R5: With mode bit 0 = 1 (non-overlapping), a `cmp_b` pulse without `cmp_a` clears each pattern bit whose enable is 1 and whose staged value is 0, at the next edge. All other bits keep their value.
- R6: With mode bit 0 = 0 (normal), `cmp_b` has no effect on the pattern register.
- R7: When `cmp_a` and `cmp_b` are high in the same cycle, only the `cmp_a` rule applies.
- R8: With `alt_sel[i]` = 0, `pin_out[i]` equals pattern bit i when direction bit i is 1, and is 0 otherwise. `pin_oe[i]` equals direction bit i.
- R9: With `alt_sel[i]` = 1, `pin_out[i]` = `alt_val[i]` and `pin_oe[i]` = 1. Strobes still update pattern bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| cmp_a | input | 1 | Compare-match A strobe |
| cmp_b | input | 1 | Compare-match B strobe |
| alt_sel | input | 16 | Per-bit hand-over to the alternate function |
| alt_val | input | 16 | Alternate function pin values |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |

## Verification
The hardest case to reach is strobe B acting on a register that already holds 1s, where the staged pattern mixes 0s and 1s under a partial enable mask. Only then do the "copy zeros only" rule and the mask show up together at the pins. The stimulus table chains its vectors without reset, so each vector starts from the pattern the previous one left behind. It places a B strobe after patterns of all 1s, partial masks, an all-ones staging value that B must not copy, and a cycle with A and B together whose two results differ.

// File: rtl/pattern_out_ctrl.sv
module pattern_out_ctrl #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  input  logic              cmp_a,
  input  logic              cmp_b,
  input  logic [WIDTH-1:0]  alt_sel,
  input  logic [WIDTH-1:0]  alt_val,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam logic [ADDR_W-1:0] A_STAGE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PAT   = ADDR_W'(4);

  logic [WIDTH-1:0] stage_q, en_q, dir_q, pat_q;
  logic             nonov_q;

  wire copy_b = cmp_b & ~cmp_a & nonov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      en_q    <= '0;
      dir_q   <= '0;
      nonov_q <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_STAGE: stage_q <= wdata;
        A_EN:    en_q    <= wdata;
        A_DIR:   dir_q   <= wdata;
        A_MODE:  nonov_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pat_q <= '0;
    else if (cmp_a)
      pat_q <= (pat_q & ~en_q) | (stage_q & en_q);
    else if (copy_b)
      pat_q <= pat_q & ~(en_q & ~stage_q);
  end

  always_comb begin
    case (addr)
      A_STAGE: rdata = stage_q;
      A_EN:    rdata = en_q;
      A_DIR:   rdata = dir_q;
      A_MODE:  rdata = {{(WIDTH-1){1'b0}}, nonov_q};
      A_PAT:   rdata = pat_q;
      default: rdata = '0;
    endcase
  end

  assign pin_out = (alt_sel & alt_val) | (~alt_sel & dir_q & pat_q);
  assign pin_oe  = alt_sel | dir_q;

  // R4 and R7: strobe A loads enabled bits, even when B is also high
  assert_a_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_a |=> ((pat_q & $past(en_q)) == ($past(stage_q) & $past(en_q))));

  assert_a_holds_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_a |=> ((pat_q & ~$past(en_q)) == ($past(pat_q) & ~$past(en_q))));

  // R5: B in non-overlapping mode never sets a bit and clears staged zeros
  assert_b_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_b && !cmp_a) |=> ((pat_q & ~$past(pat_q)) == '0));

  assert_b_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_b && !cmp_a && nonov_q) |=> ((pat_q & $past(en_q & ~stage_q)) == '0));

  // R6: no A and no effective B means the pattern holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_a && !(cmp_b && nonov_q)) |=> $stable(pat_q));

  // R8: an input-direction pin not handed over is quiet
  assert_quiet_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_oe) & ~alt_sel & ~dir_q) == '0);

endmodule

// File: tb/pattern_out_ctrl_bench.sv
module pattern_out_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] stage;
    logic [W-1:0] en;
    logic         mode;
    logic         a;
    logic         b;
    logic [W-1:0] expect_pat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 16'hFFFF},  // R4 full load
    '{16'h00F0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h00F0},  // R5 zeros fall
    '{16'h0F0F, 16'hFFFF, 1'b1, 1'b1, 1'b0, 16'h0F0F},  // R4
    '{16'h0000, 16'h00FF, 1'b1, 1'b0, 1'b1, 16'h0F00},  // R5 masked
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 16'h0F00},  // R5 ones not copied
    '{16'h1234, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'h0F00},  // R6 normal ignores B
    '{16'h1234, 16'hFF00, 1'b0, 1'b1, 1'b0, 16'h1200},  // R4 partial mask
    '{16'h00FF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 16'h00FF},  // R7 A wins
    '{16'hA5A5, 16'hF0F0, 1'b1, 1'b0, 1'b0, 16'h00FF}   // hold
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cmp_a = 1'b0, cmp_b = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0, alt_sel = '0, alt_val = '0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pattern_out_ctrl u_pattern_out_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cmp_a(cmp_a), .cmp_b(cmp_b), .alt_sel(alt_sel),
    .alt_val(alt_val), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic strobe(input logic a, input logic b);
    @(negedge clk); cmp_a = a; cmp_b = b;
    @(negedge clk); cmp_a = 1'b0; cmp_b = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    #(PERIOD * 3);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), d); check($sformatf("R1 reset reg %0d", i), d, '0);
    end
    check("R1 reset pin_out", pin_out, '0);
    check("R1 reset pin_oe", pin_oe, '0);
    rst_n = 1'b1;

    wr(3'd0, 16'hBEEF); rd(3'd0, d); check("R2 staging", d, 16'hBEEF);
    wr(3'd1, 16'h5A5A); rd(3'd1, d); check("R2 enable", d, 16'h5A5A);
    wr(3'd3, 16'hFFFF); rd(3'd3, d); check("R2 mode bit0 only", d, 16'h0001);
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R2 direction", d, 16'hFFFF);
    wr(3'd4, 16'hFFFF); rd(3'd4, d); check("R3 pattern write ignored", d, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VECS[v].stage);
      wr(3'd1, VECS[v].en);
      wr(3'd3, {15'd0, VECS[v].mode});
      strobe(VECS[v].a, VECS[v].b);
      rd(3'd4, d);
      check($sformatf("vector %0d R4/R5/R6/R7 pattern", v), d, VECS[v].expect_pat);
      check($sformatf("vector %0d R8 pins", v), pin_out, VECS[v].expect_pat);
    end

    // pattern now 00FF; direction per bit
    wr(3'd2, 16'h0F0F); #1;
    check("R8 direction gates pin_out", pin_out, 16'h000F);
    check("R8 pin_oe follows direction", pin_oe, 16'h0F0F);

    // hand low byte to alternate function
    alt_sel = 16'h00FF; alt_val = 16'h00A5; #1;
    check("R9 alternate value", pin_out, 16'h00A5);
    check("R9 alternate enable", pin_oe, 16'h0FFF);
    wr(3'd0, 16'h3C00); wr(3'd1, 16'hFFFF);
    strobe(1'b1, 1'b0);
    rd(3'd4, d); check("R9 transfer while handed over", d, 16'h3C00);
    check("R9 pins after transfer", pin_out, 16'h0CA5);
    alt_sel = '0; #1;
    check("R8 pins after release", pin_out, 16'h0C00);

    // R6 normal mode with zeros staged
    wr(3'd3, 16'h0000); wr(3'd0, 16'h0000);
    strobe(1'b0, 1'b1);
    rd(3'd4, d); check("R6 B ignored in normal mode", d, 16'h3C00);

    // reset mid-run clears all state
    @(negedge clk); rst_n = 1'b0; #1;
    rd(3'd4, d); check("R1 async reset pattern", d, '0);
    rd(3'd2, d); check("R1 async reset direction", d, '0);
    finish_run();
  end
endmodule